// File: doc/BRIEF.md
# Burst Address Generator

This block produces the access address for one port of a synchronous memory that is read or written in bursts. On every rising clock edge it chooses one of four actions from three active-low controls. A clear forces the address to zero. A strobe takes in an address from outside. An advance adds one to the held address. With none of the three asserted, the address stays where it is. The result is registered, and that register output is the address the memory uses for the access that follows the edge.

The controls are not gated by any chip-select. A port that is deselected still loads, advances and clears, so a controller can move the address while the data path is idle. A clear needs no extra cycle: the access right after a clearing edge goes to address zero. One instance serves one port, and a dual-ported memory uses two instances with independent clocks.

Top module: `burst_addr_gen`

## Requirements
- R1: With the synchronous active-high reset `rst` high at a rising edge, `acc_addr` is 0 after that edge, whatever the other inputs are.
- R2: With `rst` low and `cnt_clr_n` low at an edge, `acc_addr` becomes 0 after that edge, and `strobe_n`, `adv_n` and `ext_addr` have no effect in that cycle.
- R3: With `rst` and `cnt_clr_n` inactive and `strobe_n` low (`adv_n` high), `acc_addr` becomes the `ext_addr` sampled at that edge.
- R4: When `strobe_n` and `adv_n` are both low and no clear is active, the load wins: `acc_addr` becomes `ext_addr` and is not incremented.
- R5: With no clear, `strobe_n` high and `adv_n` low, `acc_addr` becomes its previous value plus one.
- R6: With no clear and both `strobe_n` and `adv_n` high, `acc_addr` keeps its value, and changes on `ext_addr` have no effect.
- R7: An advance from the all-ones address (0xFFFF at the default width) wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_clr_n | input | 1 | Counter clear, active low, highest priority |
| strobe_n | input | 1 | Address strobe, active low: load `ext_addr` |
| adv_n | input | 1 | Advance enable, active low: increment |
| ext_addr | input | AW (16) | Address from outside |
| acc_addr | output | AW (16) | Registered access address |

## Verification
Every action shows up on `acc_addr` after exactly one edge, because a single register lies between the controls and the output. The driver applies the controls at a falling edge and queues the model's address for that edge. The monitor compares the output one time unit after the next rising edge, so every queued value is checked against the edge that produced it. Hold cycles change `ext_addr` while the controls are idle, which shows at the output that the held address did not move.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ADV   = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

endpackage

// File: rtl/burst_act_decode.sv
module burst_act_decode
  import burst_addr_pkg::*;
(
  input  logic rst,
  input  logic cnt_clr_n,
  input  logic strobe_n,
  input  logic adv_n,
  output act_e act
);

  // Fixed priority: reset / clear, then load, then advance, then hold.
  always_comb begin
    if (rst || !cnt_clr_n)  act = ACT_CLEAR;
    else if (!strobe_n)     act = ACT_LOAD;
    else if (!adv_n)        act = ACT_ADV;
    else                    act = ACT_HOLD;
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  act_e          act,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] nxt_addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc_addr;

  // Plain modulo add: the all-ones value rolls over to zero.
  assign inc_addr = cur_addr + ONE;

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt_addr = '0;
      ACT_LOAD:  nxt_addr = ext_addr;
      ACT_ADV:   nxt_addr = inc_addr;
      default:   nxt_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_clr_n,
  input  logic          strobe_n,
  input  logic          adv_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr
);

  act_e          act;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] addr_q;

  burst_act_decode u_decode (
    .rst       (rst),
    .cnt_clr_n (cnt_clr_n),
    .strobe_n  (strobe_n),
    .adv_n     (adv_n),
    .act       (act)
  );

  burst_next_addr #(.AW(AW)) u_next (
    .act      (act),
    .cur_addr (addr_q),
    .ext_addr (ext_addr),
    .nxt_addr (nxt_addr)
  );

  always_ff @(posedge clk) begin
    addr_q <= nxt_addr;
  end

  assign acc_addr = addr_q;

  // ---------------- assertions ----------------
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_zero_r1: assert (acc_addr == '0);
    end
  end

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr_n |=> acc_addr == '0);

  p_load_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && !strobe_n) |=> acc_addr == $past(ext_addr));

  p_load_beats_adv_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && !strobe_n && !adv_n) |=> acc_addr == $past(ext_addr));

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && !adv_n) |=> acc_addr == $past(acc_addr) + 1'b1);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && adv_n) |=> $stable(acc_addr));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_clr_n && strobe_n && !adv_n && (&acc_addr)) |=> acc_addr == '0);

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_clr_n = 1'b1;
  logic          strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] acc_addr;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
    .clk       (clk),
    .rst       (rst),
    .cnt_clr_n (cnt_clr_n),
    .strobe_n  (strobe_n),
    .adv_n     (adv_n),
    .ext_addr  (ext_addr),
    .acc_addr  (acc_addr)
  );

  int            n_checks = 0;
  int            n_errors = 0;
  logic [AW-1:0] model = '0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  bit            done = 1'b0;

  // Driver: set inputs at a falling edge, queue the model's address.
  task automatic step(input logic r, input logic c, input logic s,
                      input logic a, input logic [AW-1:0] e);
    string tag;
    @(negedge clk);
    rst = r; cnt_clr_n = c; strobe_n = s; adv_n = a; ext_addr = e;
    if (r)               begin tag = "R1"; model = '0; end
    else if (!c)         begin tag = "R2"; model = '0; end
    else if (!s && !a)   begin tag = "R4"; model = e; end
    else if (!s)         begin tag = "R3"; model = e; end
    else if (!a)         begin tag = (&model) ? "R7" : "R5"; model = model + 1'b1; end
    else                 tag = "R6";
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: one result per rising edge, sampled just after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] exp_v;
        string t;
        exp_v = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (acc_addr !== exp_v) begin
          n_errors++;
          $display("FAIL %s: acc_addr=%h expected %h", t, acc_addr, exp_v);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: acc_addr=%h expected completion", acc_addr);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1, 0, 0, 0, 16'hABCD);
    step(1, 1, 1, 1, 16'h1111);
    // R3: loads
    step(0, 1, 0, 1, 16'h1234);
    step(0, 1, 0, 1, 16'h8000);
    // R5: advances
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 16'h0F0F);
    // R6: hold while ext_addr moves
    step(0, 1, 1, 1, 16'hFFFF);
    step(0, 1, 1, 1, 16'h0000);
    step(0, 1, 1, 1, 16'h5A5A);
    // R4: load beats advance
    step(0, 1, 0, 0, 16'h4242);
    step(0, 1, 0, 0, 16'h4242);
    // R2: clear overrides strobe and advance
    step(0, 0, 0, 0, 16'h7777);
    step(0, 1, 1, 0, 16'h7777);
    step(0, 0, 1, 1, 16'h3333);
    // R7: wrap
    step(0, 1, 0, 1, 16'hFFFE);
    step(0, 1, 1, 0, 16'h0000);
    step(0, 1, 1, 0, 16'h0000);
    step(0, 1, 1, 0, 16'h0000);
    // R1: reset in mid-run beats a load
    step(1, 1, 0, 1, 16'h9999);
    step(0, 1, 1, 0, 16'h9999);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] e;
      int sel;
      e = AW'($urandom);
      if ($urandom_range(0, 15) == 0) e = '1;
      sel = $urandom_range(0, 31);
      step(sel == 0, sel > 2, $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, e);
    end
    step(0, 1, 1, 1, 16'h0000);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule